// File: doc/BRIEF.md
# 48-bit Saturating Variable Shifter

This datapath unit shifts a 64-bit operand by a signed 8-bit count and limits the outcome to a 48-bit range. A positive count shifts left and a negative count shifts right by its magnitude. In signed mode the 48-bit result is sign-extended to 64 bits. In unsigned mode it is zero-extended.

Left shifts can overflow the 48-bit range. When saturation is enabled, an overflowing result is replaced by the nearest limit of the range and a flag is raised. Overflow is not found by inspecting the top bits of the product, because the 64-bit container is not twice the 48-bit width. Instead, the 48-bit-extended product is shifted back right by the same count and compared with the source.

One operation is accepted per cycle. Its result and flag are registered and appear one cycle after the input is marked valid.

Top module: `sat_shifter`

## Requirements
- R1: While rst_ni is low, valid_o, sat_o and result_o are all zero.
- R2: valid_o is high exactly one cycle after valid_i was high. When valid_i is low, result_o and sat_o keep their previous values.
- R3: A negative count (shamt_i[7] = 1) shifts right by its magnitude. The shift is arithmetic when signed_i = 1 and logical when signed_i = 0. A magnitude of 64 or more gives all copies of bit 63 in signed mode and zero in unsigned mode. sat_o stays low.
- R4: For a count of 0 to 47 that does not overflow, result_o is bits [47:0] of the source shifted left. Bits [63:48] copy bit 47 in signed mode and are zero in unsigned mode.
- R5: For a count of 0 to 47, an overflow is detected when the mathematical product lies outside the 48-bit range. The range is -2^47..2^47-1 in signed mode and 0..2^48-1 in unsigned mode. With sat_en_i = 1, an overflow clamps the result and sets sat_o.
- R6: For a count of 48 to 127, a zero source gives zero with sat_o low. A non-zero source with sat_en_i = 1 clamps the result and sets sat_o.
- R7: The signed clamp value is 64'h0000_7FFF_FFFF_FFFF for a source with bit 63 = 0. It is 64'hFFFF_8000_0000_0000 for a source with bit 63 = 1.
- R8: The unsigned clamp value is 64'h0000_FFFF_FFFF_FFFF.
- R9: With sat_en_i = 0, sat_o is never set.
  - A count of 0 to 47 returns the extended low 48 bits of the shifted source.
  - A count of 48 or more returns zero.
- R10: shamt_i is an 8-bit two's-complement count covering -128 to 127.
- R11: In signed mode with saturation enabled, the source 2^44 shifted left by 20 gives 64'h0000_7FFF_FFFF_FFFF with sat_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| src_i | input | 64 | Source operand |
| shamt_i | input | 8 | Signed shift count |
| signed_i | input | 1 | 1 = signed mode, 0 = unsigned mode |
| sat_en_i | input | 1 | 1 = clamp on overflow and report it |
| valid_o | output | 1 | Registered result valid |
| result_o | output | 64 | Shifted, extended or clamped result |
| sat_o | output | 1 | A clamp was applied |

## Verification
Each result and its flag are due at the first rising edge after the operation is presented, together with valid_o. The bench drives each operation on a falling edge and samples the outputs at the next falling edge, half a cycle after the register has loaded. For the hold behaviour, valid_i is dropped and the inputs are changed. The outputs are then compared one falling edge later against the values of the last accepted operation.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned SAT_W  = 48;
  localparam int unsigned CNT_W  = 8;

  typedef enum logic [1:0] {
    KIND_RIGHT     = 2'd0,
    KIND_LEFT_FIT  = 2'd1,
    KIND_LEFT_WIDE = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/sat_shift_decode.sv
module sat_shift_decode
  import sat_shift_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SAT_W = 48
) (
  input  logic [CNT_W-1:0] shamt_i,
  output shift_kind_e      kind_o,
  output logic [CNT_W-1:0] mag_o
);
  localparam logic [CNT_W-1:0] SAT_LIM = CNT_W'(SAT_W);

  logic neg;
  assign neg   = shamt_i[CNT_W-1];
  // magnitude of -2^(CNT_W-1) still fits unsigned in CNT_W bits
  assign mag_o = neg ? (~shamt_i + CNT_W'(1)) : shamt_i;

  always_comb begin
    if (neg)                  kind_o = KIND_RIGHT;
    else if (mag_o < SAT_LIM) kind_o = KIND_LEFT_FIT;
    else                      kind_o = KIND_LEFT_WIDE;
  end
endmodule

// File: rtl/sat_shift_right.sv
module sat_shift_right #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [CNT_W-1:0]  mag_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] res_o
);
  localparam logic [CNT_W-1:0] DATA_LIM = CNT_W'(DATA_W);

  logic signed [DATA_W-1:0] s_src;
  logic        [DATA_W-1:0] fill;
  logic                     too_far;

  assign s_src   = $signed(src_i);
  assign fill    = signed_i ? {DATA_W{src_i[DATA_W-1]}} : '0;
  assign too_far = (mag_i >= DATA_LIM);

  always_comb begin
    if (too_far)       res_o = fill;
    else if (signed_i) res_o = DATA_W'(s_src >>> mag_i);
    else               res_o = src_i >> mag_i;
  end
endmodule

// File: rtl/sat_shift_left.sv
module sat_shift_left #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SAT_W  = 48,
  parameter int unsigned CNT_W  = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [CNT_W-1:0]  mag_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] ext_o,
  output logic              ovf_o
);
  localparam int unsigned EXT_W = DATA_W - SAT_W;

  logic        [DATA_W-1:0] shl;
  logic        [DATA_W-1:0] back;
  logic signed [DATA_W-1:0] s_ext;
  logic                     top_bit;

  assign shl     = src_i << mag_i;
  assign top_bit = signed_i & shl[SAT_W-1];
  assign ext_o   = {{EXT_W{top_bit}}, shl[SAT_W-1:0]};
  assign s_ext   = $signed(ext_o);

  // round trip: the container is too narrow for a top-bit test
  always_comb begin
    if (signed_i) back = DATA_W'(s_ext >>> mag_i);
    else          back = ext_o >> mag_i;
  end

  assign ovf_o = (back != src_i);
endmodule

// File: rtl/sat_shift_clamp.sv
module sat_shift_clamp #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SAT_W  = 48
) (
  input  logic              src_neg_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] limit_o
);
  localparam int unsigned EXT_W = DATA_W - SAT_W;
  localparam logic [DATA_W-1:0] S_MAX = {{(EXT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {{(EXT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] U_MAX = {{EXT_W{1'b0}}, {SAT_W{1'b1}}};

  always_comb begin
    if (!signed_i)     limit_o = U_MAX;
    else if (src_neg_i) limit_o = S_MIN;
    else               limit_o = S_MAX;
  end
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
  import sat_shift_pkg::*;
#(
  parameter int unsigned DATA_W = sat_shift_pkg::DATA_W,
  parameter int unsigned SAT_W  = sat_shift_pkg::SAT_W,
  parameter int unsigned CNT_W  = sat_shift_pkg::CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CNT_W-1:0]  shamt_i,
  input  logic              signed_i,
  input  logic              sat_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              sat_o
);
  shift_kind_e       kind;
  logic [CNT_W-1:0]  mag;
  logic [DATA_W-1:0] right_res, left_ext, limit;
  logic              left_ovf, src_zero;
  logic [DATA_W-1:0] res_d;
  logic              sat_d;
  logic              valid_q, sat_q;
  logic [DATA_W-1:0] res_q;

  sat_shift_decode #(.CNT_W(CNT_W), .SAT_W(SAT_W)) u_decode (
    .shamt_i (shamt_i),
    .kind_o  (kind),
    .mag_o   (mag)
  );

  sat_shift_right #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_right (
    .src_i    (src_i),
    .mag_i    (mag),
    .signed_i (signed_i),
    .res_o    (right_res)
  );

  sat_shift_left #(.DATA_W(DATA_W), .SAT_W(SAT_W), .CNT_W(CNT_W)) u_left (
    .src_i    (src_i),
    .mag_i    (mag),
    .signed_i (signed_i),
    .ext_o    (left_ext),
    .ovf_o    (left_ovf)
  );

  sat_shift_clamp #(.DATA_W(DATA_W), .SAT_W(SAT_W)) u_clamp (
    .src_neg_i (src_i[DATA_W-1]),
    .signed_i  (signed_i),
    .limit_o   (limit)
  );

  assign src_zero = (src_i == '0);

  always_comb begin
    res_d = '0;
    sat_d = 1'b0;
    unique case (kind)
      KIND_RIGHT: res_d = right_res;
      KIND_LEFT_FIT: begin
        if (left_ovf && sat_en_i) begin
          res_d = limit;
          sat_d = 1'b1;
        end else begin
          res_d = left_ext;
        end
      end
      KIND_LEFT_WIDE: begin
        if (!src_zero && sat_en_i) begin
          res_d = limit;
          sat_d = 1'b1;
        end
      end
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      sat_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        sat_q <= sat_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign sat_o    = sat_q;
endmodule

// File: rtl/sat_shifter_chk.sv
module sat_shifter_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SAT_W  = 48,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] src_i,
  input logic [CNT_W-1:0]  shamt_i,
  input logic              signed_i,
  input logic              sat_en_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              sat_o
);
  localparam int unsigned EXT_W = DATA_W - SAT_W;
  localparam logic [DATA_W-1:0] S_MAX = {{(EXT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {{(EXT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] U_MAX = {{EXT_W{1'b0}}, {SAT_W{1'b1}}};

  assert_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(sat_o)));
  assert_right_nosat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shamt_i[CNT_W-1]) |=> !sat_o);
  assert_sext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && signed_i && !shamt_i[CNT_W-1])
      |=> (result_o[DATA_W-1:SAT_W] == {EXT_W{result_o[SAT_W-1]}}));
  assert_zext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !signed_i && !shamt_i[CNT_W-1]) |=> (result_o[DATA_W-1:SAT_W] == '0));
  assert_zero_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_i == '0) |=> (result_o == '0 && !sat_o));
  assert_slimit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && signed_i) |=> (!sat_o || result_o == S_MAX || result_o == S_MIN));
  assert_ulimit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !signed_i) |=> (!sat_o || result_o == U_MAX));
  assert_no_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sat_en_i) |=> !sat_o);
endmodule

bind sat_shifter sat_shifter_chk #(
  .DATA_W(DATA_W), .SAT_W(SAT_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sat_shifter_tb.sv
`timescale 1ns/1ps
module sat_shifter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] src_i = '0;
  logic [7:0]  shamt_i = '0;
  logic        signed_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        sat_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  sat_shifter u_dut (
    .clk_i, .rst_ni, .valid_i, .src_i, .shamt_i, .signed_i, .sat_en_i,
    .valid_o, .result_o, .sat_o
  );

  function automatic void model(input logic [63:0] src, input int s, input bit sgn,
                                input bit sen, output logic [63:0] res, output bit sat);
    logic signed [127:0] w, p, lo, hi, uhi, lim;
    lo  = -(128'sd1 <<< 47);
    hi  = (128'sd1 <<< 47) - 128'sd1;
    uhi = (128'sd1 <<< 48) - 128'sd1;
    w   = sgn ? {{64{src[63]}}, src} : {64'd0, src};
    lim = !sgn ? uhi : (src[63] ? lo : hi);
    sat = 1'b0;
    if (s < 0) begin
      p   = sgn ? (w >>> (-s)) : (w >> (-s));
      res = p[63:0];
    end else if (s >= 48) begin
      if (src != 0 && sen) begin
        res = lim[63:0];
        sat = 1'b1;
      end else begin
        res = '0;
      end
    end else begin
      p = w <<< s;
      if (sen && (sgn ? (p < lo || p > hi) : (p > uhi))) begin
        res = lim[63:0];
        sat = 1'b1;
      end else begin
        res = sgn ? {{16{p[47]}}, p[47:0]} : {16'd0, p[47:0]};
      end
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] act_r, input logic [63:0] exp_r,
                       input bit act_s, input bit exp_s, input bit act_v);
    n_vec++;
    if (act_r !== exp_r || act_s !== exp_s || act_v !== 1'b1) begin
      n_bad++;
      $display("FAIL %s src=%h sh=%0d sgn=%0b sen=%0b: result=%h sat=%0b valid=%0b expected result=%h sat=%0b valid=1",
               tag, src_i, $signed(shamt_i), signed_i, sat_en_i, act_r, act_s, act_v, exp_r, exp_s);
    end
  endtask

  // drive at a falling edge, sample at the next one
  task automatic apply(input logic [63:0] src, input int s, input bit sgn, input bit sen,
                       input string tag);
    logic [63:0] er;
    bit es;
    src_i = src; shamt_i = 8'(s); signed_i = sgn; sat_en_i = sen; valid_i = 1'b1;
    model(src, s, sgn, sen, er, es);
    @(negedge clk_i);
    check(tag, result_o, er, sat_o, es, valid_o);
  endtask

  function automatic string tag_of(input int s, input bit sen, input bit exp_sat);
    if (s < 0)       return "R3/R10";
    if (!sen)        return "R9";
    if (s >= 48)     return "R6/R7/R8";
    if (exp_sat)     return "R5/R7/R8";
    return "R4";
  endfunction

  logic [63:0] srcs [14] = '{
    64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_8000_0000_0000,
    64'hFFFF_8000_0000_0000, 64'h0000_7FFF_FFFF_FFFF, 64'hFFFF_8000_0000_0001,
    64'h0000_1000_0000_0000, 64'h0000_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
    64'h3
  };

  initial begin
    logic [63:0] er, held_r;
    bit es, held_s;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    n_vec++;
    if (valid_o !== 1'b0 || sat_o !== 1'b0 || result_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: valid=%0b sat=%0b result=%h expected 0 0 0", valid_o, sat_o, result_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 directed case
    apply(64'h0000_1000_0000_0000, 20, 1'b1, 1'b1, "R11");
    n_vec++;
    if (result_o !== 64'h0000_7FFF_FFFF_FFFF || sat_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: result=%h sat=%0b expected 00007fffffffffff 1", result_o, sat_o);
    end

    // full count sweep, both modes, saturation on and off
    for (int si = 0; si < 14; si++) begin
      for (int s = -128; s < 128; s++) begin
        for (int m = 0; m < 4; m++) begin
          model(srcs[si], s, m[0], m[1], er, es);
          apply(srcs[si], s, m[0], m[1], tag_of(s, m[1], es));
        end
      end
    end

    // R2 hold: drop valid, change every input
    apply(64'hFFFF_8000_0000_0000, 3, 1'b1, 1'b1, "R5/R7");
    held_r = result_o;
    held_s = sat_o;
    valid_i = 1'b0; src_i = 64'h5; shamt_i = 8'd1; signed_i = 1'b0; sat_en_i = 1'b0;
    @(negedge clk_i);
    n_vec++;
    if (valid_o !== 1'b0 || result_o !== held_r || sat_o !== held_s) begin
      n_bad++;
      $display("FAIL R2 hold: valid=%0b result=%h sat=%0b expected valid=0 result=%h sat=%0b",
               valid_o, result_o, sat_o, held_r, held_s);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule